// File: doc/BRIEF.md
# Network Controller Command and Interrupt Registers

This block is the 16-bit host-visible control and status register file of an Ethernet controller. A host reaches it through a word-addressed port with a fixed one-cycle read latency. Writing the command register launches work in the datapath engines (frame transmit, receive-resource fetch, address-filter load, timer start and stop) through one-clock action pulses; each engine reports completion on a done input, which retires the matching pending bit. The engines raise interrupt causes through set pulses, and a single level interrupt line reports any unmasked cause.

Writes are handled per register. The status register is write-one-to-clear. The three error tallies store the inverse of what is written. The data configuration register accepts writes only while the controller is held in reset mode. Several control registers drop their read-only bits. The receiver enable/disable bits and the timer start/stop bits each cancel their partner.

Top module: `nic_ctrl_regs`

## Requirements
- R1: After hardware reset the command register (address 0) reads 0x0094 (reset bit 7, timer-stop bit 4, receiver-disable bit 2), end-of-buffer count (address 6) reads 0x02F8, revision (address 7) reads 0x0004, the other registers read 0 and `irq` is low.
- R2: `bus_rdata` carries the register at `bus_addr` in the cycle after `bus_rd`; addresses 11 to 15 read 0. Map: 1 data config, 2 receive control, 3 transmit control, 4 interrupt mask, 5 interrupt status, 8 to 10 tallies.
- R3: `irq` equals the OR of (mask AND status) of the register contents in every cycle, so it changes in the same cycle as a mask write or status change becomes visible.
- R4: Bit 15 of the interrupt mask is always stored as 0.
- R5: A status write clears only bits written as 1; a bit of `evt_set` sets its status bit in the next cycle and wins over a clear of that bit in the same cycle.
- R6: Writing 1 to status bit 5 (receive resources exhausted) while it is set issues an `act_fetch` pulse and sets command bit 8; writing it while clear does neither.
- R7: A command write outside reset mode ORs the data into the register under mask 0x03BF; bit 1 gives `act_tx`, bit 8 `act_fetch`, bit 9 `act_cam`, each one clock wide in the cycle after the write; `eng_done[0]`, `[1]`, `[2]` clear command bits 1, 8, 9.
- R8: Writing receiver enable (bit 3) clears disable (bit 2) and the reverse; writing timer start (bit 5) clears stop (bit 4) and the reverse, pulsing `act_tmr_start` or `act_tmr_stop`. When both of a pair are written, disable or stop wins.
- R9: In reset mode a command write without bit 7 only clears bit 7: no pulse, no other bit changes.
- R10: A command write with bit 7 clears bits 9, 8, 3, 1, 0, sets bits 7 and 2, and issues no action pulse.
- R11: The data configuration register takes writes only in reset mode, under mask 0xBFFF.
- R12: Transmit control keeps only bits 15:12 of a write; receive control keeps bits 15:5.
- R13: Each tally register reads the bitwise inverse of the last value written.
- R14: The revision register ignores writes; the end-of-buffer count stores writes as written.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high hardware reset |
| bus_wr | input | 1 | Register write strobe |
| bus_rd | input | 1 | Register read strobe |
| bus_addr | input | ADDR_W | Word address |
| bus_wdata | input | REG_W | Write data |
| bus_rdata | output | REG_W | Read data, valid the cycle after bus_rd |
| evt_set | input | REG_W | Interrupt cause set pulses from the engines |
| eng_done | input | 3 | Completion pulses: transmit, fetch, filter load |
| act_tx | output | 1 | Transmit action pulse |
| act_fetch | output | 1 | Resource fetch action pulse |
| act_cam | output | 1 | Address-filter load action pulse |
| act_tmr_start | output | 1 | Timer start pulse |
| act_tmr_stop | output | 1 | Timer stop pulse |
| irq | output | 1 | Interrupt request level |

## Verification
An engine set pulse and a host write-one-to-clear of the same status bit can land in one cycle; the bench drives both on the same edge and expects the bit to survive and `irq` to stay high. Likewise a done pulse and a fresh command write share a cycle in the pending-bit logic, judged by reading the command register afterwards. Enable and disable of one pair in a single write are provoked and the resulting register value and pulses compared against the disable-wins rule.

// File: rtl/nic_regs_pkg.sv
package nic_regs_pkg;
  localparam int REG_W = 16;

  // register word addresses
  localparam int A_CMD   = 0;
  localparam int A_CFG   = 1;
  localparam int A_RXC   = 2;
  localparam int A_TXC   = 3;
  localparam int A_IMSK  = 4;
  localparam int A_ISTS  = 5;
  localparam int A_EOB   = 6;
  localparam int A_REV   = 7;
  localparam int A_TALLY = 8;

  // command bit positions (decoded by the engines)
  localparam int B_HALT   = 0;
  localparam int B_TX     = 1;
  localparam int B_RXDIS  = 2;
  localparam int B_RXEN   = 3;
  localparam int B_TSTOP  = 4;
  localparam int B_TSTART = 5;
  localparam int B_RST    = 7;
  localparam int B_FETCH  = 8;
  localparam int B_CAM    = 9;

  // status bit for exhausted receive resources
  localparam int B_RBE = 5;

  localparam logic [REG_W-1:0] CMD_KEEP  = 16'h03BF;
  localparam logic [REG_W-1:0] CMD_INIT  = 16'h0094;
  localparam logic [REG_W-1:0] CFG_KEEP  = 16'hBFFF;
  localparam logic [REG_W-1:0] TXC_KEEP  = 16'hF000;
  localparam logic [REG_W-1:0] RXC_KEEP  = 16'hFFE0;
  localparam logic [REG_W-1:0] IMSK_KEEP = 16'h7FFF;
endpackage

// File: rtl/nic_cmd_unit.sv
module nic_cmd_unit
  import nic_regs_pkg::*;
#(
  parameter int DW = REG_W
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          wr_cmd,
  input  logic [DW-1:0] wdata,
  input  logic [2:0]    eng_done,
  input  logic          fetch_req,
  output logic [DW-1:0] cmd_q,
  output logic          act_tx,
  output logic          act_fetch,
  output logic          act_cam,
  output logic          act_tmr_start,
  output logic          act_tmr_stop
);
  logic [DW-1:0] cmd_n;
  logic p_tx, p_fetch, p_cam, p_start, p_stop;

  always_comb begin
    cmd_n   = cmd_q;
    p_tx    = 1'b0;
    p_fetch = 1'b0;
    p_cam   = 1'b0;
    p_start = 1'b0;
    p_stop  = 1'b0;
    // engine completion retires pending work first
    if (eng_done[0]) cmd_n[B_TX]    = 1'b0;
    if (eng_done[1]) cmd_n[B_FETCH] = 1'b0;
    if (eng_done[2]) cmd_n[B_CAM]   = 1'b0;
    if (fetch_req) begin
      cmd_n[B_FETCH] = 1'b1;
      p_fetch        = 1'b1;
    end
    if (wr_cmd) begin
      if (cmd_q[B_RST] && !wdata[B_RST]) begin
        cmd_n[B_RST] = 1'b0;
      end else begin
        cmd_n = cmd_n | (wdata & DW'(CMD_KEEP));
        if (wdata[B_RXDIS])      cmd_n[B_RXEN]  = 1'b0;
        else if (wdata[B_RXEN])  cmd_n[B_RXDIS] = 1'b0;
        if (wdata[B_TSTOP])      cmd_n[B_TSTART] = 1'b0;
        else if (wdata[B_TSTART]) cmd_n[B_TSTOP] = 1'b0;
        if (wdata[B_RST]) begin
          cmd_n[B_CAM]   = 1'b0;
          cmd_n[B_FETCH] = 1'b0;
          cmd_n[B_TX]    = 1'b0;
          cmd_n[B_HALT]  = 1'b0;
          cmd_n[B_RXEN]  = 1'b0;
          cmd_n[B_RXDIS] = 1'b1;
          cmd_n[B_RST]   = 1'b1;
        end else begin
          p_tx    = wdata[B_TX];
          p_fetch = p_fetch | wdata[B_FETCH];
          p_cam   = wdata[B_CAM];
          p_start = wdata[B_TSTART] & ~wdata[B_TSTOP];
          p_stop  = wdata[B_TSTOP];
        end
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      cmd_q         <= DW'(CMD_INIT);
      act_tx        <= 1'b0;
      act_fetch     <= 1'b0;
      act_cam       <= 1'b0;
      act_tmr_start <= 1'b0;
      act_tmr_stop  <= 1'b0;
    end else begin
      cmd_q         <= cmd_n;
      act_tx        <= p_tx;
      act_fetch     <= p_fetch;
      act_cam       <= p_cam;
      act_tmr_start <= p_start;
      act_tmr_stop  <= p_stop;
    end
  end
endmodule

// File: rtl/nic_irq_unit.sv
module nic_irq_unit
  import nic_regs_pkg::*;
#(
  parameter int DW = REG_W
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          wr_mask,
  input  logic          wr_stat,
  input  logic [DW-1:0] wdata,
  input  logic [DW-1:0] evt_set,
  output logic [DW-1:0] mask_q,
  output logic [DW-1:0] stat_q,
  output logic          fetch_req,
  output logic          irq
);
  logic [DW-1:0] mask_n, stat_n, clr_bits;

  always_comb begin
    clr_bits  = wr_stat ? (wdata & stat_q) : '0;
    mask_n    = wr_mask ? (wdata & DW'(IMSK_KEEP)) : mask_q;
    // a cause raised in this cycle outlives a clear of the same bit
    stat_n    = (stat_q & ~clr_bits) | evt_set;
    fetch_req = clr_bits[B_RBE];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      mask_q <= '0;
      stat_q <= '0;
      irq    <= 1'b0;
    end else begin
      mask_q <= mask_n;
      stat_q <= stat_n;
      irq    <= |(mask_n & stat_n);
    end
  end
endmodule

// File: rtl/nic_cfg_unit.sv
module nic_cfg_unit
  import nic_regs_pkg::*;
#(
  parameter int          DW        = REG_W,
  parameter int          NUM_TALLY = 3,
  parameter logic [15:0] EOB_INIT  = 16'h02F8
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 in_rst_mode,
  input  logic                 wr_cfg,
  input  logic                 wr_rxc,
  input  logic                 wr_txc,
  input  logic                 wr_eob,
  input  logic [NUM_TALLY-1:0] wr_tally,
  input  logic [DW-1:0]        wdata,
  output logic [DW-1:0]        cfg_q,
  output logic [DW-1:0]        rxc_q,
  output logic [DW-1:0]        txc_q,
  output logic [DW-1:0]        eob_q,
  output logic [DW-1:0]        tally_q [NUM_TALLY]
);
  always_ff @(posedge clk) begin
    if (rst) begin
      cfg_q <= '0;
      rxc_q <= '0;
      txc_q <= '0;
      eob_q <= DW'(EOB_INIT);
    end else begin
      if (wr_cfg && in_rst_mode) cfg_q <= wdata & DW'(CFG_KEEP);
      if (wr_rxc) rxc_q <= wdata & DW'(RXC_KEEP);
      if (wr_txc) txc_q <= wdata & DW'(TXC_KEEP);
      if (wr_eob) eob_q <= wdata;
    end
  end

  for (genvar g = 0; g < NUM_TALLY; g++) begin : g_tally
    always_ff @(posedge clk) begin
      if (rst)              tally_q[g] <= '0;
      else if (wr_tally[g]) tally_q[g] <= ~wdata;
    end
  end
endmodule

// File: rtl/nic_ctrl_regs.sv
module nic_ctrl_regs
  import nic_regs_pkg::*;
#(
  parameter int          ADDR_W    = 4,
  parameter int          NUM_TALLY = 3,
  parameter logic [15:0] EOB_INIT  = 16'h02F8,
  parameter logic [15:0] REV_ID    = 16'h0004
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              bus_wr,
  input  logic              bus_rd,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [REG_W-1:0]  bus_wdata,
  output logic [REG_W-1:0]  bus_rdata,
  input  logic [REG_W-1:0]  evt_set,
  input  logic [2:0]        eng_done,
  output logic              act_tx,
  output logic              act_fetch,
  output logic              act_cam,
  output logic              act_tmr_start,
  output logic              act_tmr_stop,
  output logic              irq
);
  logic [REG_W-1:0] cmd_q, mask_q, stat_q;
  logic [REG_W-1:0] cfg_q, rxc_q, txc_q, eob_q;
  logic [REG_W-1:0] tally_q [NUM_TALLY];
  logic [NUM_TALLY-1:0] wr_tally;
  logic fetch_req;
  logic [REG_W-1:0] rd_n;

  function automatic logic hit(input logic [ADDR_W-1:0] a, input int idx);
    return a == ADDR_W'(idx);
  endfunction

  for (genvar g = 0; g < NUM_TALLY; g++) begin : g_tdec
    assign wr_tally[g] = bus_wr && hit(bus_addr, A_TALLY + g);
  end

  nic_cmd_unit #(.DW(REG_W)) u_cmd (
    .clk(clk), .rst(rst),
    .wr_cmd(bus_wr && hit(bus_addr, A_CMD)),
    .wdata(bus_wdata), .eng_done(eng_done), .fetch_req(fetch_req),
    .cmd_q(cmd_q), .act_tx(act_tx), .act_fetch(act_fetch), .act_cam(act_cam),
    .act_tmr_start(act_tmr_start), .act_tmr_stop(act_tmr_stop)
  );

  nic_irq_unit #(.DW(REG_W)) u_irq (
    .clk(clk), .rst(rst),
    .wr_mask(bus_wr && hit(bus_addr, A_IMSK)),
    .wr_stat(bus_wr && hit(bus_addr, A_ISTS)),
    .wdata(bus_wdata), .evt_set(evt_set),
    .mask_q(mask_q), .stat_q(stat_q), .fetch_req(fetch_req), .irq(irq)
  );

  nic_cfg_unit #(.DW(REG_W), .NUM_TALLY(NUM_TALLY), .EOB_INIT(EOB_INIT)) u_cfg (
    .clk(clk), .rst(rst), .in_rst_mode(cmd_q[B_RST]),
    .wr_cfg(bus_wr && hit(bus_addr, A_CFG)),
    .wr_rxc(bus_wr && hit(bus_addr, A_RXC)),
    .wr_txc(bus_wr && hit(bus_addr, A_TXC)),
    .wr_eob(bus_wr && hit(bus_addr, A_EOB)),
    .wr_tally(wr_tally), .wdata(bus_wdata),
    .cfg_q(cfg_q), .rxc_q(rxc_q), .txc_q(txc_q), .eob_q(eob_q), .tally_q(tally_q)
  );

  always_comb begin
    rd_n = '0;
    if (hit(bus_addr, A_CMD))  rd_n = cmd_q;
    if (hit(bus_addr, A_CFG))  rd_n = cfg_q;
    if (hit(bus_addr, A_RXC))  rd_n = rxc_q;
    if (hit(bus_addr, A_TXC))  rd_n = txc_q;
    if (hit(bus_addr, A_IMSK)) rd_n = mask_q;
    if (hit(bus_addr, A_ISTS)) rd_n = stat_q;
    if (hit(bus_addr, A_EOB))  rd_n = eob_q;
    if (hit(bus_addr, A_REV))  rd_n = REV_ID;
    for (int i = 0; i < NUM_TALLY; i++)
      if (hit(bus_addr, A_TALLY + i)) rd_n = tally_q[i];
  end

  always_ff @(posedge clk) begin
    if (rst)         bus_rdata <= '0;
    else if (bus_rd) bus_rdata <= rd_n;
  end
endmodule

// File: rtl/nic_ctrl_regs_chk.sv
module nic_ctrl_regs_chk
  import nic_regs_pkg::*;
#(
  parameter int ADDR_W = 4
) (
  input logic              clk,
  input logic              rst,
  input logic              bus_wr,
  input logic              bus_rd,
  input logic [ADDR_W-1:0] bus_addr,
  input logic [REG_W-1:0]  bus_wdata,
  input logic [REG_W-1:0]  bus_rdata,
  input logic [REG_W-1:0]  cmd_q,
  input logic [REG_W-1:0]  mask_q,
  input logic [REG_W-1:0]  stat_q,
  input logic              act_tx,
  input logic              act_fetch,
  input logic              act_cam,
  input logic              act_tmr_start,
  input logic              act_tmr_stop,
  input logic              irq
);
  logic any_act;
  assign any_act = act_tx | act_fetch | act_cam | act_tmr_start | act_tmr_stop;

  assert_irq_level_R3: assert property (@(posedge clk) disable iff (rst)
    irq == |(mask_q & stat_q));

  assert_mask_msb_R4: assert property (@(posedge clk) disable iff (rst)
    !mask_q[15]);

  assert_rbe_fetch_R6: assert property (@(posedge clk) disable iff (rst)
    (bus_wr && bus_addr == ADDR_W'(A_ISTS) && bus_wdata[B_RBE] && stat_q[B_RBE])
    |=> (act_fetch && cmd_q[B_FETCH]));

  assert_tx_cause_R7: assert property (@(posedge clk) disable iff (rst)
    act_tx |-> $past(bus_wr && bus_addr == ADDR_W'(A_CMD) && bus_wdata[B_TX]));

  assert_pair_excl_R8: assert property (@(posedge clk) disable iff (rst)
    !(cmd_q[B_RXEN] && cmd_q[B_RXDIS]) && !(cmd_q[B_TSTART] && cmd_q[B_TSTOP]));

  assert_rstmode_quiet_R9: assert property (@(posedge clk) disable iff (rst)
    (bus_wr && bus_addr == ADDR_W'(A_CMD) && cmd_q[B_RST] && !bus_wdata[B_RST])
    |=> (!any_act && !cmd_q[B_RST]));

  assert_swrst_R10: assert property (@(posedge clk) disable iff (rst)
    (bus_wr && bus_addr == ADDR_W'(A_CMD) && !cmd_q[B_RST] && bus_wdata[B_RST])
    |=> (cmd_q[B_RST] && cmd_q[B_RXDIS] && !cmd_q[B_TX] && !any_act));

  assert_rev_ro_R14: assert property (@(posedge clk) disable iff (rst)
    (bus_rd && bus_addr == ADDR_W'(A_REV)) |=> (bus_rdata == 16'h0004));
endmodule

bind nic_ctrl_regs nic_ctrl_regs_chk #(.ADDR_W(ADDR_W)) u_chk (
  .clk(clk), .rst(rst), .bus_wr(bus_wr), .bus_rd(bus_rd), .bus_addr(bus_addr),
  .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .cmd_q(cmd_q), .mask_q(mask_q),
  .stat_q(stat_q), .act_tx(act_tx), .act_fetch(act_fetch), .act_cam(act_cam),
  .act_tmr_start(act_tmr_start), .act_tmr_stop(act_tmr_stop), .irq(irq)
);

// File: tb/tb_nic_ctrl_regs.sv
module tb_nic_ctrl_regs;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        bus_wr = 1'b0, bus_rd = 1'b0;
  logic [3:0]  bus_addr = '0;
  logic [15:0] bus_wdata = '0, evt_set = '0;
  logic [2:0]  eng_done = '0;
  logic [15:0] bus_rdata;
  logic act_tx, act_fetch, act_cam, act_tmr_start, act_tmr_stop, irq;
  int n_chk = 0, n_bad = 0;
  bit finished = 1'b0;

  always #5 clk = ~clk;

  nic_ctrl_regs dut (
    .clk(clk), .rst(rst), .bus_wr(bus_wr), .bus_rd(bus_rd), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .evt_set(evt_set),
    .eng_done(eng_done), .act_tx(act_tx), .act_fetch(act_fetch), .act_cam(act_cam),
    .act_tmr_start(act_tmr_start), .act_tmr_stop(act_tmr_stop), .irq(irq)
  );

  // pulses packed as {tx, fetch, cam, start, stop}
  function automatic logic [15:0] pulses();
    return {11'd0, act_tx, act_fetch, act_cam, act_tmr_start, act_tmr_stop};
  endfunction

  task automatic chk(input string req, input logic [15:0] got, input logic [15:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_bad++;
      $display("FAIL %s: got 0x%04h expected 0x%04h", req, got, exp);
    end
  endtask

  // one bus cycle; returns at the negedge after the active edge
  task automatic cyc(input logic wr, input logic [3:0] a, input logic [15:0] d,
                     input logic [15:0] ev, input logic [2:0] dn);
    @(negedge clk);
    bus_wr = wr; bus_addr = a; bus_wdata = d; evt_set = ev; eng_done = dn;
    @(negedge clk);
    bus_wr = 1'b0; evt_set = '0; eng_done = '0;
  endtask

  task automatic wr(input logic [3:0] a, input logic [15:0] d);
    cyc(1'b1, a, d, 16'h0, 3'b000);
  endtask

  task automatic rd_chk(input string req, input logic [3:0] a, input logic [15:0] exp);
    @(negedge clk);
    bus_rd = 1'b1; bus_addr = a;
    @(negedge clk);
    bus_rd = 1'b0;
    chk(req, bus_rdata, exp);
  endtask

  task automatic t_reset();
    rd_chk("R1 cmd", 4'd0, 16'h0094);
    rd_chk("R1 eob", 4'd6, 16'h02F8);
    rd_chk("R1 rev", 4'd7, 16'h0004);
    rd_chk("R1 ists", 4'd5, 16'h0000);
    rd_chk("R1 tally", 4'd9, 16'h0000);
    chk("R1 irq", {15'd0, irq}, 16'h0);
    rd_chk("R2 unmapped", 4'd15, 16'h0000);
  endtask

  task automatic t_reset_mode();
    wr(4'd1, 16'hFFFF);
    rd_chk("R11 cfg in reset", 4'd1, 16'hBFFF);
    wr(4'd0, 16'h0302);
    chk("R9 no pulse", pulses(), 16'h0);
    rd_chk("R9 exit only", 4'd0, 16'h0014);
    wr(4'd1, 16'h1234);
    rd_chk("R11 cfg locked", 4'd1, 16'hBFFF);
  endtask

  task automatic t_actions();
    wr(4'd0, 16'h0002);
    chk("R7 tx pulse", pulses(), 16'h0010);
    @(negedge clk);
    chk("R7 one clock", pulses(), 16'h0);
    rd_chk("R7 tx pending", 4'd0, 16'h0016);
    cyc(1'b0, 4'd0, 16'h0, 16'h0, 3'b001);
    rd_chk("R7 tx done", 4'd0, 16'h0014);
    wr(4'd0, 16'h0300);
    chk("R7 fetch+cam", pulses(), 16'h000C);
    // done for cam arrives together with a new cam command: stays pending
    cyc(1'b1, 4'd0, 16'h0200, 16'h0, 3'b110);
    rd_chk("R7 done vs new", 4'd0, 16'h0214);
    cyc(1'b0, 4'd0, 16'h0, 16'h0, 3'b100);
    wr(4'd0, 16'h0400);
    rd_chk("R7 mask", 4'd0, 16'h0014);
  endtask

  task automatic t_pairs();
    wr(4'd0, 16'h0008);
    rd_chk("R8 rx en", 4'd0, 16'h0018);
    wr(4'd0, 16'h0020);
    chk("R8 start pulse", pulses(), 16'h0002);
    rd_chk("R8 start", 4'd0, 16'h0028);
    wr(4'd0, 16'h000C);
    rd_chk("R8 rx both", 4'd0, 16'h0024);
    wr(4'd0, 16'h0030);
    chk("R8 stop wins pulse", pulses(), 16'h0001);
    rd_chk("R8 timer both", 4'd0, 16'h0014);
  endtask

  task automatic t_swreset();
    wr(4'd0, 16'h0003);
    chk("R7 tx w/ halt", pulses(), 16'h0010);
    wr(4'd0, 16'h0080);
    chk("R10 no pulse", pulses(), 16'h0);
    rd_chk("R10 cmd", 4'd0, 16'h0094);
    wr(4'd0, 16'h0000);
    rd_chk("R9 leave", 4'd0, 16'h0014);
  endtask

  task automatic t_masks();
    wr(4'd3, 16'hFFFF); rd_chk("R12 txc", 4'd3, 16'hF000);
    wr(4'd2, 16'hFFFF); rd_chk("R12 rxc", 4'd2, 16'hFFE0);
    wr(4'd4, 16'hFFFF); rd_chk("R4 imsk", 4'd4, 16'h7FFF);
    wr(4'd8, 16'h1234); rd_chk("R13 t0", 4'd8, 16'hEDCB);
    wr(4'd9, 16'h00FF); rd_chk("R13 t1", 4'd9, 16'hFF00);
    wr(4'd10, 16'h0000); rd_chk("R13 t2", 4'd10, 16'hFFFF);
    wr(4'd7, 16'h5555); rd_chk("R14 rev", 4'd7, 16'h0004);
    wr(4'd6, 16'h0123); rd_chk("R14 eob", 4'd6, 16'h0123);
  endtask

  task automatic t_irq();
    wr(4'd4, 16'h0080);
    chk("R3 masked off", {15'd0, irq}, 16'h0);
    cyc(1'b0, 4'd0, 16'h0, 16'h0400, 3'b000);
    chk("R3 unmasked cause", {15'd0, irq}, 16'h0);
    cyc(1'b0, 4'd0, 16'h0, 16'h0080, 3'b000);
    chk("R3 raised", {15'd0, irq}, 16'h1);
    rd_chk("R5 set", 4'd5, 16'h0480);
    wr(4'd5, 16'h0081);
    chk("R3 dropped", {15'd0, irq}, 16'h0);
    rd_chk("R5 w1c", 4'd5, 16'h0400);
    cyc(1'b0, 4'd0, 16'h0, 16'h0080, 3'b000);
    cyc(1'b1, 4'd5, 16'h0080, 16'h0080, 3'b000);
    chk("R5 set wins irq", {15'd0, irq}, 16'h1);
    rd_chk("R5 set wins", 4'd5, 16'h0480);
    wr(4'd4, 16'h0000);
    chk("R3 mask clear", {15'd0, irq}, 16'h0);
  endtask

  task automatic t_rbe();
    wr(4'd5, 16'h0020);
    chk("R6 clear idle", pulses(), 16'h0);
    cyc(1'b0, 4'd0, 16'h0, 16'h0020, 3'b000);
    wr(4'd5, 16'h0020);
    chk("R6 fetch pulse", pulses(), 16'h0008);
    rd_chk("R6 fetch pending", 4'd0, 16'h0114);
    rd_chk("R6 rbe cleared", 4'd5, 16'h0480);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    t_reset();
    t_reset_mode();
    t_actions();
    t_pairs();
    t_swreset();
    t_masks();
    t_irq();
    t_rbe();
    finished = 1'b1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end
endmodule